// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block sits beside an SDRAM command path and turns a burst start into the stream of column addresses that the burst touches, one address per clock. A 12-bit mode word, written through a load strobe, selects the burst length (1, 2, 4, 8 or a whole 1024-column row), the ordering (linear or XOR-interleaved), whether writes are cut to a single column, and the CAS latency. The decoded latency is available on a port, and an error flag goes high whenever the stored mode word holds an encoding that is not permitted.

Fixed-length bursts stay inside the aligned block that the start column falls in. They wrap at the block edge and never carry into the upper column bits. A full-row burst advances through the row, wraps at 1024 and keeps going until a terminate strobe stops it. A new start strobe cuts off any burst in progress. For reads, a data-valid pulse train follows the address-valid pattern, delayed by the CAS latency, so that the capture logic knows when returning data is due.

Top module: `sdram_burst_seq`

## Requirements
- R1: The mode word is stored on the clock edge where `mode_ld` is high. Bits [6:4] give the CAS latency: 010 gives `cas_lat`=2 and 011 gives `cas_lat`=3. Any other value gives `cas_lat`=0 and sets `mode_err`.
- R2: Bits [2:0] give the burst length: 000=1, 001=2, 010=4, 011=8, 111=full row. A fixed-length burst raises `col_vld` for exactly that many cycles, and `col_last` is high only on the final beat.
- R3: With bit [3]=0, a burst of length L starting at column C stays in the aligned block C−(C mod L). It visits offsets (C mod L + i) mod L for beats i=0..L−1.
- R4: With bit [3]=1, beat i of a burst of length L (L ≥ 2) addresses the block base plus ((C mod L) XOR i).
- R5: With length 1, the single beat addresses C exactly, whatever the value of bit [3].
- R6: A full-row burst addresses (C+i) mod 1024 on beat i. It never raises `col_last` and runs until it is terminated.
- R7: With bit [9]=1, a write burst (`start_rd`=0) has a single beat at column C, while a read still uses the programmed length.
- R8: `mode_err` is set when bits [8:7] or bits [11:10] are not 00, when the length code is reserved, when a full row is combined with bit [3]=1, or when the CAS code is reserved. While `mode_err` is high, `start` does not begin a burst.
- R9: `term` high at a clock edge, without `start`, ends the running burst, so `col_vld` is low from that edge on.
- R10: `start` at a clock edge begins a new burst even if one is running, and even if `term` is high at the same edge. The first address (C) appears right after that edge.
- R11: `rd_vld` equals the value of `col_vld` on a read burst delayed by `cas_lat` cycles. It stays low for write bursts.
- R12: After reset, `col_vld`, `col_last` and `rd_vld` are low. The stored mode selects length 1, linear order and latency 2, so `cas_lat`=2 and `mode_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ld | input | 1 | Load strobe for the mode word |
| mode_word | input | 12 | Mode word: length [2:0], order [3], latency [6:4], op [8:7], write single [9], spare [11:10] |
| start | input | 1 | Burst start strobe |
| start_col | input | 10 | Starting column of the burst |
| start_rd | input | 1 | 1 = read burst, 0 = write burst |
| term | input | 1 | Terminate strobe for the running burst |
| col_addr | output | 10 | Column address of the current beat |
| col_vld | output | 1 | `col_addr` is a beat of a burst |
| col_last | output | 1 | Current beat is the last of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency (0 when the latency code is reserved) |
| mode_err | output | 1 | Stored mode word contains a reserved encoding |
| rd_vld | output | 1 | Read data due, delayed by the CAS latency |

## Verification
A start strobe that is sampled at a rising edge shows its first address in the cycle right after that edge. Each later beat follows one clock after the one before, and `rd_vld` for beat i is due `cas_lat` clocks after that beat. A mode load or a terminate strobe takes effect from the edge that samples it. The bench drives inputs on falling edges and reads every output on the following falling edges. It counts beats from the first falling edge after the start edge, which gives exact cycle indices for address, last-beat and read-valid expectations. Random bursts over all valid modes are mixed with directed wrap, restart, terminate and reserved-word cases.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Length field codes of the mode word
    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_ROW  = 3'b111;

    // Latency field codes of the mode word
    localparam logic [2:0] LAT_2    = 3'b010;
    localparam logic [2:0] LAT_3    = 3'b011;

    // Decoded view of the mode word
    typedef struct packed {
        logic       ilv;      // interleaved order
        logic       wr_one;   // writes are single beat
        logic [1:0] lat;      // 2 or 3, 0 when reserved
        logic       row;      // full-row burst
        logic [1:0] len_log;  // log2 of fixed burst length
        logic       err;      // reserved encoding present
    } mode_dec_t;

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
    import burst_seq_pkg::*;
(
    input  logic [11:0] word,
    output mode_dec_t   dec
);
    logic len_bad;
    logic lat_bad;
    logic fld_bad;

    always_comb begin
        dec         = '0;
        dec.ilv     = word[3];
        dec.wr_one  = word[9];
        len_bad     = 1'b0;
        unique case (word[2:0])
            LEN_1:   dec.len_log = 2'd0;
            LEN_2:   dec.len_log = 2'd1;
            LEN_4:   dec.len_log = 2'd2;
            LEN_8:   dec.len_log = 2'd3;
            LEN_ROW: dec.row     = 1'b1;
            default: len_bad     = 1'b1;
        endcase
        unique case (word[6:4])
            LAT_2:   dec.lat = 2'd2;
            LAT_3:   dec.lat = 2'd3;
            default: dec.lat = 2'd0;
        endcase
        lat_bad = (dec.lat == 2'd0);
        fld_bad = (word[8:7] != 2'b00) || (word[11:10] != 2'b00);
        dec.err = len_bad || lat_bad || fld_bad || (dec.row && word[3]);
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_rd,
    input  logic             term,
    input  mode_dec_t        mode,
    output logic [COL_W-1:0] col_addr,
    output logic             col_vld,
    output logic             col_last,
    output logic             col_rd
);
    localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             act;
        logic             rd;
        logic             ilv;
        logic             row;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
    } gen_st_t;

    gen_st_t          st_d, st_q;
    logic             single;
    logic             at_end;
    logic [COL_W-1:0] off;
    logic [COL_W-1:0] idx;

    assign at_end = !st_q.row && (st_q.beat == st_q.mask);

    always_comb begin
        st_d   = st_q;
        single = mode.wr_one && !start_rd;
        if (go) begin
            st_d.act  = 1'b1;
            st_d.rd   = start_rd;
            st_d.ilv  = mode.ilv;
            st_d.row  = mode.row && !single;
            st_d.base = start_col;
            st_d.beat = '0;
            if (single)
                st_d.mask = '0;
            else if (mode.row)
                st_d.mask = '1;
            else
                st_d.mask = (ONE << mode.len_log) - ONE;
        end else if (term) begin
            st_d.act = 1'b0;
        end else if (st_q.act) begin
            if (at_end)
                st_d.act = 1'b0;
            else
                st_d.beat = st_q.beat + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        off = st_q.base & st_q.mask;
        if (st_q.ilv)
            idx = off ^ st_q.beat;
        else
            idx = off + st_q.beat;
        col_addr = (st_q.base & ~st_q.mask) | (idx & st_q.mask);
        col_vld  = st_q.act;
        col_last = st_q.act && at_end;
        col_rd   = st_q.act && st_q.rd;
    end

    p_first_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (col_vld && col_addr == $past(start_col)));

    p_term_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !go) |=> !col_vld);

    p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !go) |=> !col_vld);

    p_last_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_vld);

    p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mode.wr_one && !start_rd) |=> col_last);

endmodule

// File: rtl/burst_rdv_delay.sv
module burst_rdv_delay #(
    parameter int MAX_LAT = 3,
    localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] lat,
    input  logic             in_vld,
    output logic             out_vld
);
    logic [MAX_LAT-1:0] sh_d, sh_q;

    generate
        if (MAX_LAT == 1) begin : g_one
            always_comb sh_d = in_vld;
        end else begin : g_many
            always_comb sh_d = {sh_q[MAX_LAT-2:0], in_vld};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= sh_d;
    end

    always_comb begin
        if (lat == '0)
            out_vld = 1'b0;
        else
            out_vld = sh_q[lat - 1'b1];
    end

    p_delay_two_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lat == 2 && $past(lat) == 2 && $past(lat, 2) == 2) |-> (out_vld == $past(in_vld, 2)));

    p_delay_three_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lat == 3 && $past(lat) == 3 && $past(lat, 2) == 3 && $past(lat, 3) == 3)
        |-> (out_vld == $past(in_vld, 3)));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import burst_seq_pkg::*;
#(
    parameter int          COL_W      = 10,
    parameter int          MAX_LAT    = 3,
    parameter logic [11:0] RESET_MODE = 12'h020
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ld,
    input  logic [11:0]      mode_word,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_rd,
    input  logic             term,
    output logic [COL_W-1:0] col_addr,
    output logic             col_vld,
    output logic             col_last,
    output logic [1:0]       cas_lat,
    output logic             mode_err,
    output logic             rd_vld
);
    logic [11:0] mode_d, mode_q;
    mode_dec_t   dec;
    logic        go;
    logic        col_rd;

    always_comb begin
        mode_d = mode_q;
        if (mode_ld)
            mode_d = mode_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= RESET_MODE;
        else
            mode_q <= mode_d;
    end

    burst_mode_dec u_dec (
        .word (mode_q),
        .dec  (dec)
    );

    assign go       = start && !dec.err;
    assign cas_lat  = dec.lat;
    assign mode_err = dec.err;

    burst_col_gen #(.COL_W(COL_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .start_col (start_col),
        .start_rd  (start_rd),
        .term      (term),
        .mode      (dec),
        .col_addr  (col_addr),
        .col_vld   (col_vld),
        .col_last  (col_last),
        .col_rd    (col_rd)
    );

    burst_rdv_delay #(.MAX_LAT(MAX_LAT)) u_rdv (
        .clk     (clk),
        .rst_n   (rst_n),
        .lat     (cas_lat),
        .in_vld  (col_rd),
        .out_vld (rd_vld)
    );

    p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err && start && !col_vld) |=> !col_vld);

    p_lat_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_err |-> (cas_lat == 2'd2 || cas_lat == 2'd3));

    p_ld_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ld && mode_word[6:4] == 3'b011) |=> cas_lat == 2'd3);

endmodule

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_ld;
    logic [11:0] mode_word;
    logic        start;
    logic [9:0]  start_col;
    logic        start_rd;
    logic        term;
    logic [9:0]  col_addr;
    logic        col_vld;
    logic        col_last;
    logic [1:0]  cas_lat;
    logic        mode_err;
    logic        rd_vld;

    int n_tests = 0;
    int n_fail  = 0;

    int g_len = 1;
    bit g_ilv = 0;
    int g_cl  = 2;
    bit g_wb  = 0;

    always #4 clk = ~clk;

    sdram_burst_seq uut (
        .clk (clk), .rst_n (rst_n), .mode_ld (mode_ld), .mode_word (mode_word),
        .start (start), .start_col (start_col), .start_rd (start_rd), .term (term),
        .col_addr (col_addr), .col_vld (col_vld), .col_last (col_last),
        .cas_lat (cas_lat), .mode_err (mode_err), .rd_vld (rd_vld)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_addr(int col, int i, int len, bit ilv);
        int blk, off;
        if (len == 1) return col;
        if (len == 1024) return (col + i) % 1024;
        off = col % len;
        blk = col - off;
        if (ilv) return blk + (off ^ i);
        return blk + ((off + i) % len);
    endfunction

    task automatic load_word(logic [11:0] w);
        mode_ld   = 1'b1;
        mode_word = w;
        @(negedge clk);
        mode_ld   = 1'b0;
    endtask

    // len_code: 0..3 fixed, 7 full row
    task automatic set_mode(int len_code, bit ilv, int cl, bit wb);
        logic [2:0] lc;
        logic [2:0] cc;
        lc = 3'(len_code);
        cc = (cl == 3) ? 3'b011 : 3'b010;
        load_word({2'b00, wb, 2'b00, cc, ilv, lc});
        g_len = (len_code == 7) ? 1024 : (1 << len_code);
        g_ilv = ilv;
        g_cl  = cl;
        g_wb  = wb;
        check(mode_err == 1'b0, "R1", "mode_err after valid load", int'(mode_err), 0);
        check(int'(cas_lat) == cl, "R1", "cas_lat decode", int'(cas_lat), cl);
    endtask

    task automatic run_burst(int col, bit rd, string tag);
        int  len;
        bit  ev, er;
        len       = (g_wb && !rd) ? 1 : g_len;
        start     = 1'b1;
        start_col = 10'(col);
        start_rd  = rd;
        @(negedge clk);
        start     = 1'b0;
        for (int i = 0; i < len + g_cl + 2; i++) begin
            ev = (i < len);
            er = rd && (i >= g_cl) && (i < g_cl + len);
            check(col_vld == ev, tag, $sformatf("col_vld beat %0d", i), int'(col_vld), int'(ev));
            if (ev) begin
                check(int'(col_addr) == exp_addr(col, i, g_len == 1024 ? 1024 : len, g_ilv),
                      tag, $sformatf("col_addr beat %0d", i), int'(col_addr),
                      exp_addr(col, i, g_len == 1024 ? 1024 : len, g_ilv));
                check(col_last == (i == len - 1), "R2", $sformatf("col_last beat %0d", i),
                      int'(col_last), int'(i == len - 1));
            end
            check(rd_vld == er, "R11", $sformatf("rd_vld slot %0d", i), int'(rd_vld), int'(er));
            @(negedge clk);
        end
    endtask

    task automatic bad_word(logic [11:0] w, bit lat_bad, string what);
        load_word(w);
        check(mode_err == 1'b1, "R8", what, int'(mode_err), 1);
        if (lat_bad)
            check(cas_lat == 2'd0, "R1", "cas_lat for reserved code", int'(cas_lat), 0);
        start     = 1'b1;
        start_col = 10'd5;
        start_rd  = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        check(col_vld == 1'b0, "R8", {what, " start ignored"}, int'(col_vld), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int mk, len_code, col;
        bit rd;
        rst_n     = 1'b0;
        mode_ld   = 1'b0;
        mode_word = '0;
        start     = 1'b0;
        start_col = '0;
        start_rd  = 1'b0;
        term      = 1'b0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check(col_vld == 1'b0, "R12", "col_vld reset", int'(col_vld), 0);
        check(col_last == 1'b0, "R12", "col_last reset", int'(col_last), 0);
        check(rd_vld == 1'b0, "R12", "rd_vld reset", int'(rd_vld), 0);
        check(cas_lat == 2'd2, "R12", "cas_lat reset", int'(cas_lat), 2);
        check(mode_err == 1'b0, "R12", "mode_err reset", int'(mode_err), 0);
        run_burst(123, 1'b1, "R12");

        // R3 linear wrap inside block of 8
        set_mode(3, 1'b0, 3, 1'b0);
        run_burst(45, 1'b1, "R3");
        set_mode(2, 1'b0, 2, 1'b0);
        run_burst(1023, 1'b0, "R3");

        // R4 interleaved
        set_mode(3, 1'b1, 2, 1'b0);
        run_burst(45, 1'b1, "R4");
        set_mode(1, 1'b1, 3, 1'b0);
        run_burst(301, 1'b1, "R4");

        // R5 single beat ignores order bit
        set_mode(0, 1'b1, 2, 1'b0);
        run_burst(777, 1'b1, "R5");

        // R7 write single with read at full length
        set_mode(2, 1'b0, 3, 1'b1);
        run_burst(14, 1'b0, "R7");
        run_burst(14, 1'b1, "R7");

        // R6 full row wrap, then R9 terminate
        set_mode(7, 1'b0, 2, 1'b0);
        start     = 1'b1;
        start_col = 10'd1020;
        start_rd  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 10; i++) begin
            check(col_vld == 1'b1, "R6", "row burst running", int'(col_vld), 1);
            check(int'(col_addr) == (1020 + i) % 1024, "R6", "row address",
                  int'(col_addr), (1020 + i) % 1024);
            check(col_last == 1'b0, "R6", "no last in row burst", int'(col_last), 0);
            if (i == 9) term = 1'b1;
            @(negedge clk);
        end
        term = 1'b0;
        check(col_vld == 1'b0, "R9", "row burst terminated", int'(col_vld), 0);
        repeat (5) @(negedge clk);

        // R9 terminate fixed burst
        set_mode(3, 1'b0, 2, 1'b0);
        start     = 1'b1;
        start_col = 10'd8;
        start_rd  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        check(col_vld == 1'b0, "R9", "fixed burst terminated", int'(col_vld), 0);
        repeat (6) @(negedge clk);
        check(rd_vld == 1'b0, "R11", "rd_vld drained after terminate", int'(rd_vld), 0);

        // R10 restart during burst, and start beating term
        start     = 1'b1;
        start_col = 10'd16;
        start_rd  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start     = 1'b1;
        start_col = 10'd203;
        @(negedge clk);
        start = 1'b0;
        check(col_vld == 1'b1, "R10", "restart valid", int'(col_vld), 1);
        check(int'(col_addr) == 203, "R10", "restart first address", int'(col_addr), 203);
        @(negedge clk);
        check(int'(col_addr) == 204, "R10", "restart second address", int'(col_addr), 204);
        start     = 1'b1;
        term      = 1'b1;
        start_col = 10'd300;
        @(negedge clk);
        start = 1'b0;
        term  = 1'b0;
        check(col_vld == 1'b1 && int'(col_addr) == 300, "R10", "start wins over term",
              int'(col_addr), 300);
        repeat (12) @(negedge clk);
        check(col_vld == 1'b0, "R2", "burst ended after eight beats", int'(col_vld), 0);

        // R8 reserved words
        bad_word(12'b00_0_01_010_0_001, 1'b0, "op field nonzero");
        bad_word(12'b10_0_00_010_0_001, 1'b0, "spare field nonzero");
        bad_word(12'b00_0_00_010_0_100, 1'b0, "reserved length");
        bad_word(12'b00_0_00_010_1_111, 1'b0, "full row interleaved");
        bad_word(12'b00_0_00_001_0_001, 1'b1, "reserved latency");
        bad_word(12'b00_0_00_100_0_011, 1'b1, "latency code 100");

        // random bursts over valid modes
        for (int k = 0; k < 80; k++) begin
            mk = $urandom % 4;
            len_code = mk;
            set_mode(len_code, 1'($urandom % 2), 2 + int'($urandom % 2), 1'($urandom % 2));
            col = int'($urandom % 1024);
            rd  = 1'($urandom % 2);
            run_burst(col, rd, g_ilv ? "R4" : "R3");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule